// File: doc/BRIEF.md
# H-Bridge Gate Controller with Dead Time

This block turns two motor-bridge commands into the four gate enables of an H-bridge. Each of the two output legs has a high-side and a low-side switch. The commands come either from two external input pins or from two register bits, and a select input picks the source. Before the pins are decoded, each one passes through a filter that suppresses glitches. The register bits are used as they are.

A mode input chooses how the pair of commands is read. In direction mode, one command acts as an enable and the other as the direction. In two-input mode, each command drives one side, and the two separate stop states are available: braking (both outputs low) and coasting (both outputs high-impedance). An active-low sleep input forces every switch off.

Each leg has its own sequencer. When a leg changes between driving high and driving low, the sequencer holds both of that leg's switches off for a programmable number of clock cycles. A leg enters or leaves the high-impedance state without waiting. All control inputs are sampled on the rising clock edge.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: When `bridge_sel`=1, `reg_a` and `reg_b` are the commands and the pins are ignored. When `bridge_sel`=0, the filtered `pin_a` and `pin_b` are the commands and the register bits are ignored. Command A is enable/IN1 and command B is phase/IN2.
- R2: In direction mode (`pwm_mode`=0) with `sleep_n`=1, the targets are as follows. A=0 sets both legs low (brake). A=1, B=1 sets leg 1 high and leg 2 low (forward). A=1, B=0 sets leg 1 low and leg 2 high (reverse).
- R3: In two-input mode (`pwm_mode`=1) with `sleep_n`=1, the targets for A/B are: 0/0 both legs off (coast), 1/0 forward, 0/1 reverse, 1/1 both legs low (brake).
- R4: With `sleep_n`=0, all four gate enables are 0 one cycle later, whatever the mode or the commands.
- R5: A leg that moves between high and low keeps both of its enables at 0 for exactly max(`dead_cycles`,1) cycles before the new enable turns on. `dead_cycles` is sampled when the leg enters the dead interval.
- R6: A leg whose target becomes off turns its enables off on the next cycle, even in the middle of a dead interval. A leg leaving the off state drives its new level on the next cycle, with no dead interval.
- R7: A pin level is accepted only after it has been sampled at STABLE_N consecutive rising edges. A pulse sampled at fewer edges leaves the outputs unchanged.
- R8: The high-side and low-side enables of one leg are never 1 in the same cycle. Neither enable of a leg follows the other enable of that leg in the next cycle.
- R9: A synchronous active-low reset forces all four enables to 0 and clears the filter and dead-time counters. After reset, the block follows its inputs again from the first edge.
- R10: A change in a register command, the mode or sleep affects the outputs after one edge. A change on a pin affects them after STABLE_N+1 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sleep_n | input | 1 | 0 turns every switch off |
| bridge_sel | input | 1 | Command source: 0 pins, 1 register bits |
| pwm_mode | input | 1 | Decode: 0 direction mode, 1 two-input mode |
| pin_a | input | 1 | External command A (enable / IN1), filtered |
| pin_b | input | 1 | External command B (phase / IN2), filtered |
| reg_a | input | 1 | Register command A (enable / IN1) |
| reg_b | input | 1 | Register command B (phase / IN2) |
| dead_cycles | input | DT_W | Dead interval in clock cycles (0 acts as 1) |
| hs1 | output | 1 | Leg 1 high-side enable |
| ls1 | output | 1 | Leg 1 low-side enable |
| hs2 | output | 1 | Leg 2 high-side enable |
| ls2 | output | 1 | Leg 2 low-side enable |

## Verification
The enables are decoded directly from each leg's state register. A sequencer that is in the wrong state therefore shows a wrong enable pair on the very next cycle. A dead counter that runs short or long moves the first cycle of the new drive away from the expected cycle, and the bench samples at that exact cycle. A filter that accepts too early or too late shifts the pin-path response away from STABLE_N+1 edges, or lets a short pulse reach the legs. The checker flags, in the same cycle, any overlap of the two enables of one leg or any direct change from one enable to the other.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  // Target a decoder asks of one leg.
  typedef enum logic [1:0] {
    CMD_OFF  = 2'd0,
    CMD_HIGH = 2'd1,
    CMD_LOW  = 2'd2
  } leg_cmd_t;

  // State of a per-leg sequencer.
  typedef enum logic [1:0] {
    ST_IDLE_OFF   = 2'd0,
    ST_DRIVE_HIGH = 2'd1,
    ST_DRIVE_LOW  = 2'd2,
    ST_DEAD       = 2'd3
  } leg_st_t;

endpackage

// File: rtl/hbg_deglitch.sv
module hbg_deglitch #(
  parameter int STABLE_N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = (STABLE_N > 1) ? $clog2(STABLE_N) : 1;
  localparam logic [CW-1:0] LAST = CW'(STABLE_N - 1);

  logic [CW-1:0] run_q;

  // The accepted level changes only after STABLE_N differing samples in a row.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout  <= 1'b0;
      run_q <= '0;
    end else if (din == dout) begin
      run_q <= '0;
    end else if (run_q == LAST) begin
      dout  <= din;
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/hbg_decode.sv
module hbg_decode
  import hbg_pkg::*;
(
  input  logic     sleep_n,
  input  logic     bridge_sel,
  input  logic     pwm_mode,
  input  logic     pin_a_f,
  input  logic     pin_b_f,
  input  logic     reg_a,
  input  logic     reg_b,
  output leg_cmd_t leg1_tgt,
  output leg_cmd_t leg2_tgt
);
  logic cmd_a, cmd_b;

  always_comb begin
    cmd_a = bridge_sel ? reg_a : pin_a_f;
    cmd_b = bridge_sel ? reg_b : pin_b_f;
  end

  always_comb begin
    leg1_tgt = CMD_OFF;
    leg2_tgt = CMD_OFF;
    if (!sleep_n) begin
      leg1_tgt = CMD_OFF;
      leg2_tgt = CMD_OFF;
    end else if (!pwm_mode) begin
      // direction mode: A enables, B selects the direction
      if (!cmd_a) begin
        leg1_tgt = CMD_LOW;
        leg2_tgt = CMD_LOW;
      end else if (cmd_b) begin
        leg1_tgt = CMD_HIGH;
        leg2_tgt = CMD_LOW;
      end else begin
        leg1_tgt = CMD_LOW;
        leg2_tgt = CMD_HIGH;
      end
    end else begin
      // two-input mode: each command drives one side
      case ({cmd_a, cmd_b})
        2'b10: begin leg1_tgt = CMD_HIGH; leg2_tgt = CMD_LOW;  end
        2'b01: begin leg1_tgt = CMD_LOW;  leg2_tgt = CMD_HIGH; end
        2'b11: begin leg1_tgt = CMD_LOW;  leg2_tgt = CMD_LOW;  end
        default: begin leg1_tgt = CMD_OFF; leg2_tgt = CMD_OFF; end
      endcase
    end
  end
endmodule

// File: rtl/hbg_leg_seq.sv
module hbg_leg_seq
  import hbg_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  leg_cmd_t        target,
  input  logic [DT_W-1:0] dead_cycles,
  output logic            hs_en,
  output logic            ls_en
);
  localparam logic [DT_W-1:0] ONE = DT_W'(1);

  leg_st_t         st_q, st_d;
  logic [DT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      ST_IDLE_OFF: begin
        if (target == CMD_HIGH)     st_d = ST_DRIVE_HIGH;
        else if (target == CMD_LOW) st_d = ST_DRIVE_LOW;
      end
      ST_DRIVE_HIGH: begin
        if (target == CMD_LOW) begin
          st_d  = ST_DEAD;
          cnt_d = dead_cycles;
        end else if (target != CMD_HIGH) begin
          st_d = ST_IDLE_OFF;
        end
      end
      ST_DRIVE_LOW: begin
        if (target == CMD_HIGH) begin
          st_d  = ST_DEAD;
          cnt_d = dead_cycles;
        end else if (target != CMD_LOW) begin
          st_d = ST_IDLE_OFF;
        end
      end
      default: begin // ST_DEAD
        if (target != CMD_HIGH && target != CMD_LOW) begin
          st_d  = ST_IDLE_OFF;
          cnt_d = '0;
        end else if (cnt_q <= ONE) begin
          st_d  = (target == CMD_HIGH) ? ST_DRIVE_HIGH : ST_DRIVE_LOW;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE_OFF;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign hs_en = (st_q == ST_DRIVE_HIGH);
  assign ls_en = (st_q == ST_DRIVE_LOW);
endmodule

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl
  import hbg_pkg::*;
#(
  parameter int STABLE_N = 4,
  parameter int DT_W     = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sleep_n,
  input  logic            bridge_sel,
  input  logic            pwm_mode,
  input  logic            pin_a,
  input  logic            pin_b,
  input  logic            reg_a,
  input  logic            reg_b,
  input  logic [DT_W-1:0] dead_cycles,
  output logic            hs1,
  output logic            ls1,
  output logic            hs2,
  output logic            ls2
);
  localparam int NUM_PINS = 2;
  localparam int NUM_LEGS = 2;

  logic [NUM_PINS-1:0] pin_raw, pin_flt;
  leg_cmd_t            leg1_tgt, leg2_tgt;
  leg_cmd_t            tgt [NUM_LEGS];
  logic [NUM_LEGS-1:0] hs_v, ls_v;

  assign pin_raw = {pin_b, pin_a};

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_flt
    hbg_deglitch #(.STABLE_N(STABLE_N)) u_dg (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pin_raw[g]),
      .dout (pin_flt[g])
    );
  end

  hbg_decode u_dec (
    .sleep_n   (sleep_n),
    .bridge_sel(bridge_sel),
    .pwm_mode  (pwm_mode),
    .pin_a_f   (pin_flt[0]),
    .pin_b_f   (pin_flt[1]),
    .reg_a     (reg_a),
    .reg_b     (reg_b),
    .leg1_tgt  (leg1_tgt),
    .leg2_tgt  (leg2_tgt)
  );

  assign tgt[0] = leg1_tgt;
  assign tgt[1] = leg2_tgt;

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    hbg_leg_seq #(.DT_W(DT_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .target     (tgt[g]),
      .dead_cycles(dead_cycles),
      .hs_en      (hs_v[g]),
      .ls_en      (ls_v[g])
    );
  end

  assign hs1 = hs_v[0];
  assign ls1 = ls_v[0];
  assign hs2 = hs_v[1];
  assign ls2 = ls_v[1];
endmodule

// File: rtl/hbg_chk.sv
module hbg_chk (
  input logic clk,
  input logic rst_n,
  input logic sleep_n,
  input logic bridge_sel,
  input logic pwm_mode,
  input logic reg_a,
  input logic reg_b,
  input logic hs1,
  input logic ls1,
  input logic hs2,
  input logic ls2
);
  p_leg1_excl_r8: assert property (@(posedge clk) disable iff (!rst_n) !(hs1 && ls1));
  p_leg2_excl_r8: assert property (@(posedge clk) disable iff (!rst_n) !(hs2 && ls2));
  p_leg1_hi_gap_r5: assert property (@(posedge clk) disable iff (!rst_n) hs1 |=> !ls1);
  p_leg1_lo_gap_r5: assert property (@(posedge clk) disable iff (!rst_n) ls1 |=> !hs1);
  p_leg2_hi_gap_r5: assert property (@(posedge clk) disable iff (!rst_n) hs2 |=> !ls2);
  p_leg2_lo_gap_r5: assert property (@(posedge clk) disable iff (!rst_n) ls2 |=> !hs2);
  p_sleep_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |=> !(hs1 || ls1 || hs2 || ls2));
  p_coast_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_n && bridge_sel && pwm_mode && !reg_a && !reg_b) |=> !(hs1 || ls1 || hs2 || ls2));
endmodule

bind hbridge_gate_ctrl hbg_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sleep_n   (sleep_n),
  .bridge_sel(bridge_sel),
  .pwm_mode  (pwm_mode),
  .reg_a     (reg_a),
  .reg_b     (reg_b),
  .hs1       (hs1),
  .ls1       (ls1),
  .hs2       (hs2),
  .ls2       (ls2)
);

// File: tb/sim_hbridge_gate_ctrl.sv
module sim_hbridge_gate_ctrl;
  localparam int N   = 3;
  localparam int DTW = 8;
  localparam int D   = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, sleep_n, bridge_sel, pwm_mode, pin_a, pin_b, reg_a, reg_b;
  logic [DTW-1:0] dead_cycles;
  logic hs1, ls1, hs2, ls2;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  hbridge_gate_ctrl #(.STABLE_N(N), .DT_W(DTW)) u0 (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .bridge_sel(bridge_sel),
    .pwm_mode(pwm_mode), .pin_a(pin_a), .pin_b(pin_b), .reg_a(reg_a),
    .reg_b(reg_b), .dead_cycles(dead_cycles),
    .hs1(hs1), .ls1(ls1), .hs2(hs2), .ls2(ls2)
  );

  typedef struct {
    int        at;
    logic [3:0] val;
    string     tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // driver side: expected enables {hs1,ls1,hs2,ls2} at a given cycle
  task automatic expect_at(int at, logic [3:0] v, string tag);
    exp_t e;
    e.at = at; e.val = v; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compares away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (e.at < cyc || {hs1, ls1, hs2, ls2} !== e.val) begin
        errors++;
        $display("FAIL %s at cycle %0d: actual=%b expected=%b",
                 e.tag, cyc, {hs1, ls1, hs2, ls2}, e.val);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int c;
    rst_n = 1'b0; sleep_n = 1'b0; bridge_sel = 1'b0; pwm_mode = 1'b0;
    pin_a = 1'b0; pin_b = 1'b0; reg_a = 1'b0; reg_b = 1'b0;
    dead_cycles = DTW'(D);
    step(3);
    c = cyc; expect_at(c + 1, 4'b0000, "R9 reset state");
    step(1);
    // register source, direction mode, enable low -> brake
    rst_n = 1'b1; sleep_n = 1'b1; bridge_sel = 1'b1;
    c = cyc; expect_at(c + 1, 4'b0101, "R2 R10 brake from registers");
    step(3);
    // forward: leg 1 low->high runs the dead interval
    reg_a = 1'b1; reg_b = 1'b1;
    c = cyc;
    expect_at(c + 1, 4'b0001, "R5 dead start");
    expect_at(c + D, 4'b0001, "R5 dead last cycle");
    expect_at(c + D + 1, 4'b1001, "R2 forward");
    step(D + 3);
    // reverse: both legs flip
    reg_b = 1'b0;
    c = cyc;
    expect_at(c + 1, 4'b0000, "R5 R8 both legs dead");
    expect_at(c + D, 4'b0000, "R5 still dead");
    expect_at(c + D + 1, 4'b0110, "R2 reverse");
    step(D + 3);
    // two-input mode
    pwm_mode = 1'b1; reg_a = 1'b0; reg_b = 1'b0;
    c = cyc; expect_at(c + 1, 4'b0000, "R3 R6 coast at once");
    step(2);
    reg_a = 1'b1;
    c = cyc; expect_at(c + 1, 4'b1001, "R6 R3 forward from coast");
    step(2);
    reg_b = 1'b1;
    c = cyc;
    expect_at(c + 1, 4'b0001, "R5 brake dead leg 1");
    expect_at(c + D + 1, 4'b0101, "R3 brake");
    step(D + 3);
    reg_a = 1'b0;
    c = cyc;
    expect_at(c + 1, 4'b0100, "R5 reverse dead leg 2");
    expect_at(c + D + 1, 4'b0110, "R3 reverse");
    step(D + 3);
    // sleep
    sleep_n = 1'b0;
    c = cyc; expect_at(c + 1, 4'b0000, "R4 sleep");
    step(3);
    sleep_n = 1'b1;
    c = cyc; expect_at(c + 1, 4'b0110, "R6 wake without dead");
    step(2);
    // pin source, two-input mode, filtered pins are 0/0
    bridge_sel = 1'b0;
    c = cyc; expect_at(c + 1, 4'b0000, "R1 pins selected coast");
    step(2);
    pin_a = 1'b1;
    c = cyc;
    expect_at(c + N, 4'b0000, "R10 pin not yet accepted");
    expect_at(c + N + 1, 4'b1001, "R7 R10 pin accepted");
    step(N + 3);
    // short pulse of N-1 samples
    c = cyc;
    expect_at(c + 1, 4'b1001, "R7 pulse start");
    expect_at(c + N + 2, 4'b1001, "R7 pulse rejected");
    pin_b = 1'b1;
    step(N - 1);
    pin_b = 1'b0;
    step(N + 4);
    // register bits must not matter with pins selected
    reg_a = 1'b0; reg_b = 1'b1;
    c = cyc;
    expect_at(c + 1, 4'b1001, "R1 regs ignored");
    expect_at(c + 3, 4'b1001, "R1 regs still ignored");
    step(4);
    // direction mode on pins: A=1, B=0 -> reverse
    pwm_mode = 1'b0;
    c = cyc;
    expect_at(c + 1, 4'b0000, "R5 dead on mode change");
    expect_at(c + D, 4'b0000, "R5 dead end");
    expect_at(c + D + 1, 4'b0110, "R2 reverse from pins");
    step(D + 3);
    // zero dead time acts as one cycle
    dead_cycles = '0; pin_b = 1'b1;
    c = cyc;
    expect_at(c + N + 1, 4'b0000, "R5 minimum one dead cycle");
    expect_at(c + N + 2, 4'b1001, "R5 forward after one");
    step(N + 4);
    // coast aborts the dead interval
    dead_cycles = DTW'(6); bridge_sel = 1'b1; pwm_mode = 1'b1;
    reg_a = 1'b1; reg_b = 1'b1;
    c = cyc; expect_at(c + 1, 4'b0001, "R3 brake entry");
    step(1);
    reg_a = 1'b0; reg_b = 1'b0;
    c = cyc; expect_at(c + 1, 4'b0000, "R6 coast aborts dead");
    step(1);
    reg_b = 1'b1;
    c = cyc; expect_at(c + 1, 4'b0110, "R6 reverse from coast");
    step(2);
    // reset in operation
    rst_n = 1'b0;
    c = cyc; expect_at(c + 1, 4'b0000, "R9 reset clears drive");
    step(1);
    rst_n = 1'b1;
    c = cyc; expect_at(c + 1, 4'b0110, "R9 drive after reset");
    step(4);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule